// File: doc/BRIEF.md
# Eight-Source Interrupt Arbiter with Four External Inputs

This block collects interrupt requests from four active-low external pins and four request lines from on-chip peripherals (two timer overflows, the third timer and the serial port). It holds every per-source control bit, picks one winning source, and presents the winner's index and priority level to the CPU with a single request line. Each external pin can trigger on a falling edge, which latches a flag, or on a low level, where the flag simply follows the pin.

Software reaches the controls through four byte-wide registers with a per-bit write mask, so a single bit can be set or cleared without touching its neighbours. The two extra external inputs keep all their controls (type, flag, enable, priority) in a register of their own. The CPU acknowledges the winner, which clears that source's edge flag and marks its level as in service. A return pulse ends the most recent service. The block lets a high-priority request interrupt a low-priority service, but nothing interrupts a high-priority service.

Top module: `irq_arb8`

## Requirements
- R1: After a synchronous reset all four registers read 0x00, every flag is clear and `irq_req` is low.
- R2: With the type bit at 1 (edge), a pin sampled high and then low on the next clock sets its flag. The flag is visible two clock edges after the pin falls and stays set after the pin returns high.
- R3: With the type bit at 0 (level), the flag is the inverted sampled pin, two edges behind the pin. It clears again when the pin goes high, and an acknowledge does not clear it.
- R4: Register 2 holds, from bit 7 down, prio3, en3, flag3, type3, prio2, en2, flag2, type2. Only the bits set in `reg_wmask` are written.
- R5: Register 0 (enables) and register 1 (priorities) use bit 0 INT0, bit 1 timer 0, bit 2 INT1, bit 3 timer 1, bit 4 serial, bit 5 timer 2. `periph_req` is {timer 2, serial, timer 1, timer 0} from bit 3 down.
- R6: Bit 7 of register 0 is a global enable. When it is clear, no request is raised.
- R7: A pending, enabled high-priority source wins over every low-priority source.
- R8: Within one priority level the winner is the first pending source in the order INT0, T0, INT1, T1, serial, T2, INT2, INT3 (indices 0 to 7).
- R9: An acknowledge while `irq_req` is high clears only the winner's flag, and only if that source is an edge-mode external input.
- R10: After acknowledging a low-priority winner, only high-priority requests are raised. After acknowledging a high-priority winner, none are raised.
- R11: `irq_ret` ends the high-level service if one is active, otherwise the low-level one.
- R12: Register 3 holds type0 in bit 0, flag0 in bit 1, type1 in bit 2, flag1 in bit 3 and reads 0 in bits 7:4. `reg_rdata` shows the register chosen by `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_n | input | 4 | External interrupt pins INT0..INT3, active low |
| periph_req | input | 4 | Peripheral request lines {T2, serial, T1, T0} |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 priority, 2 extra external, 3 type/flag |
| reg_wmask | input | 8 | Per-bit write mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_ack | input | 1 | CPU takes the current winner |
| irq_ret | input | 1 | CPU leaves the current service level |
| irq_req | output | 1 | Request to the CPU |
| irq_idx | output | 3 | Winning source index |
| irq_hi | output | 1 | Winner is high priority |

## Verification
The hardest state to reach is nesting: a low-priority service in progress, a high-priority request arriving on top of it, and two returns unwinding in the right order. The stimulus builds it from the peripheral lines. It acknowledges a low-priority timer, raises a high-priority timer, and acknowledges that one too. It then withdraws the high request and returns twice, checking between steps that low requests stay masked until the second return. Edge flags are also loaded directly by masked writes, so the priority and polling table can fill every flag at once without pulsing pins.

// File: rtl/irq_arb8_pkg.sv
// Shared constants for the eight-source interrupt arbiter.
package irq_arb8_pkg;
    localparam int NSRC    = 8;                 // arbitrated sources
    localparam int NEXT    = 4;                 // external pins
    localparam int IDXW    = $clog2(NSRC);      // index width
    localparam int REGW    = 8;                 // register width

    // Polling order within one level (lower index polled first).
    typedef enum logic [IDXW-1:0] {
        SRC_X0  = 3'd0,
        SRC_T0  = 3'd1,
        SRC_X1  = 3'd2,
        SRC_T1  = 3'd3,
        SRC_SER = 3'd4,
        SRC_T2  = 3'd5,
        SRC_X2  = 3'd6,
        SRC_X3  = 3'd7
    } src_e;

    // Register select codes.
    localparam logic [1:0] SEL_EN  = 2'd0;
    localparam logic [1:0] SEL_PRI = 2'd1;
    localparam logic [1:0] SEL_XC  = 2'd2;
    localparam logic [1:0] SEL_TY  = 2'd3;
endpackage

// File: rtl/irq_pin_unit.sv
// One external interrupt input: samples the active-low pin on two
// successive clocks and holds the request flag. Edge mode latches on a
// sampled 1-then-0; level mode makes the flag the inverted sample.
// Assumes the pin is already synchronous to clk.
module irq_pin_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic flag_wr,
    input  logic flag_wdata,
    input  logic clr,
    output logic flag
);
    logic s0_q, s1_q;
    logic fall;

    // Two-stage sample of the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_q <= 1'b1;
            s1_q <= 1'b1;
        end else begin
            s0_q <= pin_n;
            s1_q <= s0_q;
        end
    end

    assign fall = s1_q & ~s0_q;

    // Flag update: software write wins, then hardware set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (flag_wr)
            flag <= flag_wdata;
        else if (!edge_mode)
            flag <= ~s0_q;
        else if (fall)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assert_edge_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall && !flag_wr) |=> flag);

    assert_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && flag && !clr && !flag_wr) |=> flag);
endmodule

// File: rtl/irq_select.sv
// Priority selector: picks the first candidate in polling order at the
// high level, else at the low level, and gates it by the service state.
// Assumes pend/en/hi vectors are indexed in polling order.
module irq_select
    import irq_arb8_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] hi,
    input  logic            ea,
    input  logic            act_lo,
    input  logic            act_hi,
    output logic            req,
    output logic [IDXW-1:0] idx,
    output logic            win_hi
);
    logic [NSRC-1:0] cand, cand_hi, cand_lo;
    logic [IDXW-1:0] hidx, lidx;

    assign cand    = pend & en & {NSRC{ea}};
    assign cand_hi = cand & hi;
    assign cand_lo = cand & ~hi;

    // First set bit of each level, scanning down so the lowest index wins.
    always_comb begin
        hidx = '0;
        lidx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand_hi[i]) hidx = IDXW'(i);
            if (cand_lo[i]) lidx = IDXW'(i);
        end
    end

    // Level choice and nesting gate.
    always_comb begin
        win_hi = |cand_hi;
        idx    = win_hi ? hidx : lidx;
        if (win_hi)
            req = !act_hi;
        else
            req = (|cand_lo) && !act_hi && !act_lo;
    end

    assert_win_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (pend[idx] && en[idx] && (hi[idx] == win_hi)));

    assert_nest_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        act_hi |-> !req);
endmodule

// File: rtl/irq_arb8.sv
// Eight-source interrupt arbiter: control registers, four external pin
// units, selector and a two-level in-service tracker.
// Assumes ack is only meaningful while irq_req is high.
module irq_arb8
    import irq_arb8_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_pin_n,
    input  logic [3:0]      periph_req,
    input  logic            reg_wr,
    input  logic [1:0]      reg_sel,
    input  logic [REGW-1:0] reg_wmask,
    input  logic [REGW-1:0] reg_wdata,
    output logic [REGW-1:0] reg_rdata,
    input  logic            irq_ack,
    input  logic            irq_ret,
    output logic            irq_req,
    output logic [IDXW-1:0] irq_idx,
    output logic            irq_hi
);
    logic [REGW-1:0] en_q, pri_q, xc_q, ty_q;
    logic [NEXT-1:0] flag, ext_edge, fwr, fwd, fclr;
    logic [NSRC-1:0] pend, src_en, src_hi;
    logic            act_lo, act_hi, take;

    // Masked writes to the stored control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pri_q <= '0;
            xc_q  <= '0;
            ty_q  <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_EN:  en_q  <= (en_q  & ~reg_wmask) | (reg_wdata & reg_wmask);
                SEL_PRI: pri_q <= (pri_q & ~reg_wmask) | (reg_wdata & reg_wmask);
                SEL_XC:  xc_q  <= (xc_q  & ~reg_wmask) | (reg_wdata & reg_wmask);
                default: ty_q  <= (ty_q  & ~reg_wmask) | (reg_wdata & reg_wmask);
            endcase
        end
    end

    // Per-pin type, flag-write bit position and source index.
    assign ext_edge = {xc_q[4], xc_q[0], ty_q[2], ty_q[0]};
    assign take     = irq_ack && irq_req;

    // Flag write strobes and data for each pin.
    always_comb begin
        fwr  = '0;
        fwd  = '0;
        fwr[0] = reg_wr && (reg_sel == SEL_TY) && reg_wmask[1];
        fwd[0] = reg_wdata[1];
        fwr[1] = reg_wr && (reg_sel == SEL_TY) && reg_wmask[3];
        fwd[1] = reg_wdata[3];
        fwr[2] = reg_wr && (reg_sel == SEL_XC) && reg_wmask[1];
        fwd[2] = reg_wdata[1];
        fwr[3] = reg_wr && (reg_sel == SEL_XC) && reg_wmask[5];
        fwd[3] = reg_wdata[5];
        fclr[0] = take && (irq_idx == SRC_X0);
        fclr[1] = take && (irq_idx == SRC_X1);
        fclr[2] = take && (irq_idx == SRC_X2);
        fclr[3] = take && (irq_idx == SRC_X3);
    end

    for (genvar k = 0; k < NEXT; k++) begin : g_pin
        irq_pin_unit u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_n      (ext_pin_n[k]),
            .edge_mode  (ext_edge[k]),
            .flag_wr    (fwr[k]),
            .flag_wdata (fwd[k]),
            .clr        (fclr[k]),
            .flag       (flag[k])
        );
    end

    // Source vectors in polling order.
    assign pend   = {flag[3], flag[2], periph_req[3], periph_req[2],
                     periph_req[1], flag[1], periph_req[0], flag[0]};
    assign src_en = {xc_q[6], xc_q[2], en_q[5:0]};
    assign src_hi = {xc_q[7], xc_q[3], pri_q[5:0]};

    irq_select u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .en     (src_en),
        .hi     (src_hi),
        .ea     (en_q[7]),
        .act_lo (act_lo),
        .act_hi (act_hi),
        .req    (irq_req),
        .idx    (irq_idx),
        .win_hi (irq_hi)
    );

    // In-service tracker: ack pushes the winner's level, return pops the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_lo <= 1'b0;
            act_hi <= 1'b0;
        end else if (take) begin
            if (irq_hi) act_hi <= 1'b1;
            else        act_lo <= 1'b1;
        end else if (irq_ret) begin
            if (act_hi) act_hi <= 1'b0;
            else        act_lo <= 1'b0;
        end
    end

    // Read mux with live flags merged in.
    always_comb begin
        case (reg_sel)
            SEL_EN:  reg_rdata = en_q & 8'hBF;
            SEL_PRI: reg_rdata = pri_q & 8'h3F;
            SEL_XC:  reg_rdata = {xc_q[7:6], flag[3], xc_q[4:2], flag[2], xc_q[0]};
            default: reg_rdata = {4'b0, flag[1], ty_q[2], flag[0], ty_q[0]};
        endcase
    end

    assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> en_q[7]);

    assert_hi_nest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && irq_hi) |=> !irq_req);

    assert_ret_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack && act_hi) |=> (!act_hi && act_lo == $past(act_lo)));
endmodule

// File: tb/irq_arb8_bench.sv
// Bench: a vector table for arbitration, then directed tests.
module irq_arb8_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ext_pin_n = 4'hF;
    logic [3:0] periph_req = 4'h0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wmask = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic       irq_hi;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_arb8 u_irq_arb8 (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .periph_req(periph_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wmask(reg_wmask),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq_req(irq_req), .irq_idx(irq_idx), .irq_hi(irq_hi)
    );

    // Vector: en, pri, xc, ty, periph, req, idx, hi
    localparam int NV = 12;
    localparam logic [40:0] VEC [NV] = '{
        {8'h00, 8'h00, 8'h77, 8'h0F, 4'hF, 1'b0, 3'd0, 1'b0}, // R6 nothing enabled
        {8'h7F, 8'h00, 8'h77, 8'h0F, 4'hF, 1'b0, 3'd0, 1'b0}, // R6 EA clear
        {8'hBF, 8'h00, 8'h77, 8'h0F, 4'hF, 1'b1, 3'd0, 1'b0}, // R8 INT0 first
        {8'hBE, 8'h00, 8'h77, 8'h0F, 4'hF, 1'b1, 3'd1, 1'b0}, // R8 T0 next
        {8'h80, 8'h00, 8'h77, 8'h0F, 4'hF, 1'b1, 3'd6, 1'b0}, // R4 INT2 via xc
        {8'h80, 8'h00, 8'hF7, 8'h0F, 4'hF, 1'b1, 3'd7, 1'b1}, // R4 R7 PX3
        {8'hBF, 8'h20, 8'h77, 8'h0F, 4'hF, 1'b1, 3'd5, 1'b1}, // R7 PT2
        {8'hBF, 8'h04, 8'h77, 8'h0F, 4'hF, 1'b1, 3'd2, 1'b1}, // R7 PX1
        {8'hBF, 8'h00, 8'h77, 8'h05, 4'h0, 1'b1, 3'd6, 1'b0}, // R8 INT2 before INT3
        {8'h90, 8'h00, 8'h11, 8'h05, 4'h4, 1'b1, 3'd4, 1'b0}, // R5 serial
        {8'h88, 8'h08, 8'h11, 8'h05, 4'h2, 1'b1, 3'd3, 1'b1}, // R5 T1 high
        {8'hBF, 8'h3F, 8'hFF, 8'h0F, 4'hF, 1'b1, 3'd0, 1'b1}  // R8 all high
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] m, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wmask = m; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wmask = 8'h00;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [7:0] exp, input string tag);
        reg_sel = sel;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0;
    endtask

    task automatic out(input logic r, input logic [2:0] i, input logic h, input string tag);
        chk(irq_req == r && (!r || (irq_idx == i && irq_hi == h)), tag,
            {irq_req, irq_idx, irq_hi}, {r, i, h});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        out(1'b0, 3'd0, 1'b0, "R1 req");
        rd(2'd0, 8'h00, "R1 en");
        rd(2'd1, 8'h00, "R1 pri");
        rd(2'd2, 8'h00, "R1 xc");
        rd(2'd3, 8'h00, "R12 ty reset");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            wr(2'd0, 8'hFF, VEC[v][40:33]);
            wr(2'd1, 8'hFF, VEC[v][32:25]);
            wr(2'd2, 8'hFF, VEC[v][24:17]);
            wr(2'd3, 8'hFF, VEC[v][16:9]);
            periph_req = VEC[v][8:5];
            @(negedge clk);
            out(VEC[v][4], VEC[v][3:1], VEC[v][0], $sformatf("R7/R8 vec%0d", v));
        end
        periph_req = 4'h0;
        rd(2'd3, 8'h0F, "R12 ty layout");

        // R4 masked single-bit writes
        wr(2'd2, 8'hFF, 8'h00);
        wr(2'd2, 8'h04, 8'hFF);
        rd(2'd2, 8'h04, "R4 set en2");
        wr(2'd2, 8'h80, 8'h80);
        rd(2'd2, 8'h84, "R4 set prio3");
        wr(2'd2, 8'h04, 8'h00);
        rd(2'd2, 8'h80, "R4 clear en2");
        wr(2'd2, 8'hFF, 8'h00);
        wr(2'd1, 8'hFF, 8'h00);

        // R2 edge latch on INT0
        wr(2'd3, 8'hFF, 8'h01);
        wr(2'd0, 8'hFF, 8'h81);
        @(negedge clk); ext_pin_n[0] = 1'b0;
        @(negedge clk);
        out(1'b0, 3'd0, 1'b0, "R2 one edge");
        @(negedge clk);
        out(1'b1, 3'd0, 1'b0, "R2 two edges");
        ext_pin_n[0] = 1'b1;
        repeat (3) @(negedge clk);
        out(1'b1, 3'd0, 1'b0, "R2 held");
        // R9 ack clears edge flag, R10 low level active
        pulse_ack();
        rd(2'd3, 8'h01, "R9 flag0 cleared");
        out(1'b0, 3'd0, 1'b0, "R9 no req");
        pulse_ret();

        // R3 level mode on INT0
        wr(2'd3, 8'hFF, 8'h00);
        @(negedge clk); ext_pin_n[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        out(1'b1, 3'd0, 1'b0, "R3 level req");
        pulse_ack();
        rd(2'd3, 8'h02, "R3 ack keeps level flag");
        pulse_ret();
        @(negedge clk); ext_pin_n[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        out(1'b0, 3'd0, 1'b0, "R3 level released");
        rd(2'd3, 8'h00, "R3 flag follows pin");

        // R10/R11 nesting with timers
        wr(2'd0, 8'hFF, 8'h8A);
        wr(2'd1, 8'hFF, 8'h08);
        @(negedge clk); periph_req = 4'h1;
        @(negedge clk);
        out(1'b1, 3'd1, 1'b0, "R10 low T0");
        pulse_ack();
        out(1'b0, 3'd0, 1'b0, "R10 low blocks low");
        periph_req = 4'h3;
        @(negedge clk);
        out(1'b1, 3'd3, 1'b1, "R10 high preempts");
        pulse_ack();
        out(1'b0, 3'd0, 1'b0, "R10 high blocks all");
        periph_req = 4'h1;
        pulse_ret();
        out(1'b0, 3'd0, 1'b0, "R11 low still active");
        pulse_ret();
        out(1'b1, 3'd1, 1'b0, "R11 low released");
        periph_req = 4'h0;

        // R9 ack clears only the winner's flag
        wr(2'd1, 8'hFF, 8'h00);
        wr(2'd0, 8'hFF, 8'hBF);
        wr(2'd3, 8'hFF, 8'h03);
        wr(2'd2, 8'hFF, 8'h07);
        @(negedge clk);
        out(1'b1, 3'd0, 1'b0, "R9 INT0 wins");
        pulse_ack();
        rd(2'd3, 8'h01, "R9 winner flag cleared");
        rd(2'd2, 8'h07, "R9 other flag kept");
        pulse_ret();
        @(negedge clk);
        out(1'b1, 3'd6, 1'b0, "R9 INT2 next");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule